// File: doc/BRIEF.md
# Packet Header ECC Generator and Corrector

This block protects the 24-bit header of a serial-link packet with one error-correction byte. The header is three bytes: the identifier byte in bits [7:0] (header bit Di is `hdr_in[i]`), followed by two bytes that carry either short-packet data or a long-packet byte count. In generate mode the block computes the ECC byte for an outgoing header. In check mode it takes a received header and ECC byte and recomputes the parity. It then corrects any single flipped bit, whether in the header or in the ECC byte, and flags any pattern it cannot correct.

The corrected identifier is split into a 2-bit virtual channel (identifier bits [7:6]) and a 6-bit data type (identifier bits [5:0]). The datapath is combinational. A parameter selects whether a register stage follows it. The register stage gives a latency of one cycle; without it the latency is zero. Each request is classified by a named verdict:

- CLEAN: zero syndrome.
- FIX_HDR: the syndrome matches a header-bit column.
- FIX_ECC: the syndrome has exactly one bit set.
- BAD: any other nonzero syndrome.

Generate mode always takes the GEN path.

Top module: `hdr_ecc_unit`

## Requirements
- R1: In generate mode (`mode_check`=0), `ecc_out[7:6]` is 0 and `ecc_out[5:0]` follows these XOR sets over the header bits:
  - bit 0: D0 D1 D2 D4 D5 D7 D10 D11 D13 D16 D20 D21 D22 D23
  - bit 1: D0 D1 D3 D4 D6 D8 D10 D12 D14 D17 D20 D21 D22 D23
  - bit 2: D0 D2 D3 D5 D6 D9 D11 D12 D15 D18 D20 D21 D22
  - bit 3: D1 D2 D3 D7 D8 D9 D13 D14 D15 D19 D20 D21 D23
  - bit 4: D4 to D9, D16 to D20, D22 D23
  - bit 5: D10 to D19, D21 D22 D23
- R2: In check mode, when the received ECC equals the recomputed ECC, the header and ECC pass unchanged and both `err_fixed` and `err_bad` are 0.
- R3: In check mode, a single flipped header bit is restored in `hdr_out`, `ecc_out` equals the received ECC, and `err_fixed` is 1.
- R4: In check mode, a single flipped ECC bit (any of bits 0 to 7) leaves `hdr_out` equal to the received header. `ecc_out` carries the corrected ECC byte and `err_fixed` is 1.
- R5: In check mode, any other nonzero syndrome (for example two flipped bits) sets `err_bad`, clears `err_fixed`, and passes the header and ECC unchanged. `err_fixed` and `err_bad` are never both 1.
- R6: `vc_out` equals bits [7:6] and `dtype_out` equals bits [5:0] of the output header, after any correction.
- R7: With `REG_OUT`=1, each request presented with `in_valid` produces its result with `out_valid` exactly one cycle later. Idle cycles produce no `out_valid`. Reset clears `out_valid`, the flags and the outputs.
- R8: In generate mode, `hdr_out` equals `hdr_in` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode_check | input | 1 | 1 = check and correct, 0 = generate |
| hdr_in | input | 24 | Header; bits [7:0] are the identifier byte |
| ecc_in | input | 8 | Received ECC byte (check mode only) |
| out_valid | output | 1 | Result present |
| hdr_out | output | 24 | Header after correction |
| ecc_out | output | 8 | Generated or corrected ECC byte |
| vc_out | output | 2 | Virtual channel from corrected identifier |
| dtype_out | output | 6 | Data type from corrected identifier |
| err_fixed | output | 1 | A single-bit error was corrected |
| err_bad | output | 1 | Uncorrectable error detected |

## Verification
Correction and the identifier split fall in the same cycle when the flipped bit is identifier bit 6 or 7. In that case `vc_out` must already show the repaired channel rather than the received one. The bench provokes this by flipping each of those bits on headers whose channel field differs from its flipped value. It judges `vc_out` and `dtype_out` against a reference model that corrects first and splits afterwards. Every other header and ECC bit position is also swept singly and in pairs, so that FIX_HDR, FIX_ECC and BAD all meet the split.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;

    localparam int HDR_W = 24;
    localparam int ECC_W = 8;
    localparam int PAR_W = 6;
    localparam int VC_W  = 2;
    localparam int DT_W  = 6;
    localparam int ID_W  = VC_W + DT_W;

    // Classification of one request
    typedef enum logic [2:0] {
        V_GEN,
        V_CLEAN,
        V_FIX_HDR,
        V_FIX_ECC,
        V_BAD
    } verdict_e;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic [ECC_W-1:0] ecc;
        logic             fixed;
        logic             bad;
    } result_t;

    // Parity column of each header bit (bit p set: header bit feeds parity p)
    function automatic logic [PAR_W-1:0] column(input int unsigned idx);
        logic [PAR_W-1:0] c;
        case (idx)
            0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
            4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
            8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
            12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
            16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
            20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hdr_ecc_parity.sv
module hdr_ecc_parity
    import hdr_ecc_pkg::*;
(
    input  logic [HDR_W-1:0] data,
    output logic [ECC_W-1:0] ecc
);

    logic [PAR_W-1:0] par;

    for (genvar p = 0; p < PAR_W; p++) begin : g_par
        always_comb begin
            logic             acc;
            logic [PAR_W-1:0] col;
            acc = 1'b0;
            for (int i = 0; i < HDR_W; i++) begin
                col = column(i);
                if (col[p]) acc = acc ^ data[i];
            end
            par[p] = acc;
        end
    end

    // Top parity bits are defined as constant zero
    assign ecc = {{(ECC_W-PAR_W){1'b0}}, par};

endmodule

// File: rtl/hdr_ecc_syndrome_dec.sv
module hdr_ecc_syndrome_dec
    import hdr_ecc_pkg::*;
(
    input  logic [ECC_W-1:0] syndrome,
    output verdict_e         verdict,
    output logic [HDR_W-1:0] flip_mask
);

    logic [HDR_W-1:0] hit;

    for (genvar i = 0; i < HDR_W; i++) begin : g_hit
        assign hit[i] = (syndrome == {{(ECC_W-PAR_W){1'b0}}, column(i)});
    end

    assign flip_mask = hit;

    always_comb begin
        if (syndrome == '0)
            verdict = V_CLEAN;
        else if (|hit)
            verdict = V_FIX_HDR;
        else if ($onehot(syndrome))
            verdict = V_FIX_ECC;
        else
            verdict = V_BAD;
    end

endmodule

// File: rtl/hdr_ecc_out_stage.sv
module hdr_ecc_out_stage
    import hdr_ecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    d_valid,
    input  result_t d_res,
    output logic    q_valid,
    output result_t q_res
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_res   <= '0;
            end else begin
                q_valid <= d_valid;
                if (d_valid) q_res <= d_res;
            end
        end
    end else begin : g_wire
        assign q_valid = d_valid;
        assign q_res   = d_res;
    end

endmodule

// File: rtl/hdr_ecc_unit.sv
module hdr_ecc_unit
    import hdr_ecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_check,
    input  logic [HDR_W-1:0] hdr_in,
    input  logic [ECC_W-1:0] ecc_in,
    output logic             out_valid,
    output logic [HDR_W-1:0] hdr_out,
    output logic [ECC_W-1:0] ecc_out,
    output logic [VC_W-1:0]  vc_out,
    output logic [DT_W-1:0]  dtype_out,
    output logic             err_fixed,
    output logic             err_bad
);

    logic [ECC_W-1:0] calc_ecc;
    logic [ECC_W-1:0] syndrome;
    logic [HDR_W-1:0] flip_mask;
    verdict_e         dec_verdict;
    verdict_e         verdict;
    result_t          nxt_res;
    result_t          out_res;

    hdr_ecc_parity u_parity (
        .data (hdr_in),
        .ecc  (calc_ecc)
    );

    assign syndrome = ecc_in ^ calc_ecc;

    hdr_ecc_syndrome_dec u_dec (
        .syndrome  (syndrome),
        .verdict   (dec_verdict),
        .flip_mask (flip_mask)
    );

    assign verdict = mode_check ? dec_verdict : V_GEN;

    // Result per verdict
    always_comb begin
        nxt_res = '0;
        unique case (verdict)
            V_GEN: begin
                nxt_res.hdr = hdr_in;
                nxt_res.ecc = calc_ecc;
            end
            V_CLEAN: begin
                nxt_res.hdr = hdr_in;
                nxt_res.ecc = ecc_in;
            end
            V_FIX_HDR: begin
                nxt_res.hdr   = hdr_in ^ flip_mask;
                nxt_res.ecc   = ecc_in;
                nxt_res.fixed = 1'b1;
            end
            V_FIX_ECC: begin
                nxt_res.hdr   = hdr_in;
                nxt_res.ecc   = ecc_in ^ syndrome;
                nxt_res.fixed = 1'b1;
            end
            V_BAD: begin
                nxt_res.hdr = hdr_in;
                nxt_res.ecc = ecc_in;
                nxt_res.bad = 1'b1;
            end
            default: nxt_res = '0;
        endcase
    end

    hdr_ecc_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_res   (nxt_res),
        .q_valid (out_valid),
        .q_res   (out_res)
    );

    assign hdr_out   = out_res.hdr;
    assign ecc_out   = out_res.ecc;
    assign err_fixed = out_res.fixed;
    assign err_bad   = out_res.bad;
    assign vc_out    = out_res.hdr[ID_W-1:DT_W];
    assign dtype_out = out_res.hdr[DT_W-1:0];

endmodule

// File: rtl/hdr_ecc_unit_chk.sv
module hdr_ecc_unit_chk
    import hdr_ecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_check,
    input logic [HDR_W-1:0] hdr_in,
    input logic             out_valid,
    input logic [HDR_W-1:0] hdr_out,
    input logic [ECC_W-1:0] ecc_out,
    input logic             err_fixed,
    input logic             err_bad
);

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({err_fixed, err_bad}) <= 1);

    if (REG_OUT) begin : g_seq
        assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        assert_gen_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !mode_check) |=>
                (!err_fixed && !err_bad && hdr_out == $past(hdr_in)));

        assert_gen_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !mode_check) |=> (ecc_out[ECC_W-1:PAR_W] == '0));

        assert_hdr_change_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode_check) |=> (hdr_out == $past(hdr_in) || err_fixed));
    end

endmodule

bind hdr_ecc_unit hdr_ecc_unit_chk #(.REG_OUT(REG_OUT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_check (mode_check),
    .hdr_in     (hdr_in),
    .out_valid  (out_valid),
    .hdr_out    (hdr_out),
    .ecc_out    (ecc_out),
    .err_fixed  (err_fixed),
    .err_bad    (err_bad)
);

// File: tb/hdr_ecc_unit_tb_top.sv
`timescale 1ns/1ps
module hdr_ecc_unit_tb_top;

    typedef struct {
        logic [23:0] hdr;
        logic [7:0]  ecc;
        logic        fixed;
        logic        bad;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_check = 1'b0;
    logic [23:0] hdr_in = '0;
    logic [7:0]  ecc_in = '0;
    logic        out_valid;
    logic [23:0] hdr_out;
    logic [7:0]  ecc_out;
    logic [1:0]  vc_out;
    logic [5:0]  dtype_out;
    logic        err_fixed;
    logic        err_bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    hdr_ecc_unit #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_check(mode_check),
        .hdr_in(hdr_in), .ecc_in(ecc_in), .out_valid(out_valid), .hdr_out(hdr_out),
        .ecc_out(ecc_out), .vc_out(vc_out), .dtype_out(dtype_out),
        .err_fixed(err_fixed), .err_bad(err_bad)
    );

    // Reference parity from the XOR sets in R1
    function automatic logic [7:0] ref_ecc(input logic [23:0] d);
        logic [7:0] e;
        e[0] = ^(d & 24'hF12CB7);
        e[1] = ^(d & 24'hF2555B);
        e[2] = ^(d & 24'h749A6D);
        e[3] = ^(d & 24'hB8E38E);
        e[4] = ^(d & 24'hDF03F0);
        e[5] = ^(d & 24'hEFFC00);
        e[7:6] = 2'b00;
        return e;
    endfunction

    function automatic exp_t model(input logic mode, input logic [23:0] h,
                                   input logic [7:0] e, input string req);
        exp_t x;
        logic [7:0] syn;
        bit found;
        x.req = req; x.hdr = h; x.ecc = e; x.fixed = 1'b0; x.bad = 1'b0;
        if (!mode) begin
            x.ecc = ref_ecc(h);
            return x;
        end
        syn = e ^ ref_ecc(h);
        if (syn == 8'h00) return x;
        found = 1'b0;
        for (int i = 0; i < 24; i++) begin
            if (!found && ref_ecc(h ^ (24'h1 << i)) == e) begin
                x.hdr = h ^ (24'h1 << i);
                found = 1'b1;
            end
        end
        if (found) x.fixed = 1'b1;
        else if ($countones(syn) == 1) begin
            x.ecc = e ^ syn;
            x.fixed = 1'b1;
        end else x.bad = 1'b1;
        return x;
    endfunction

    task automatic fail_msg(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic send(input logic mode, input logic [23:0] h,
                        input logic [7:0] e, input string req);
        @(negedge clk);
        in_valid = 1'b1; mode_check = mode; hdr_in = h; ecc_in = e;
        q.push_back(model(mode, h, e, req));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t x;
            checks++;
            if (q.size() == 0) begin
                fail_msg("R7", "unexpected out_valid", 1, 0);
            end else begin
                x = q.pop_front();
                if (hdr_out !== x.hdr)
                    fail_msg(x.req, "hdr_out", {8'h0, hdr_out}, {8'h0, x.hdr});
                else if (ecc_out !== x.ecc)
                    fail_msg(x.req, "ecc_out", {24'h0, ecc_out}, {24'h0, x.ecc});
                else if (err_fixed !== x.fixed)
                    fail_msg(x.req, "err_fixed", {31'h0, err_fixed}, {31'h0, x.fixed});
                else if (err_bad !== x.bad)
                    fail_msg(x.req, "err_bad", {31'h0, err_bad}, {31'h0, x.bad});
                else if (vc_out !== x.hdr[7:6])
                    fail_msg("R6", "vc_out", {30'h0, vc_out}, {30'h0, x.hdr[7:6]});
                else if (dtype_out !== x.hdr[5:0])
                    fail_msg("R6", "dtype_out", {26'h0, dtype_out}, {26'h0, x.hdr[5:0]});
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fail_msg("R7", "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] hdrs [6];
        hdrs[0] = 24'h000000; hdrs[1] = 24'hFFFFFF; hdrs[2] = 24'h123456;
        hdrs[3] = 24'hA5C33C; hdrs[4] = 24'h0F0F81; hdrs[5] = 24'h7E0042;

        repeat (3) @(negedge clk);
        // Reset state (R7)
        checks++;
        if (out_valid !== 1'b0 || err_fixed !== 1'b0 || err_bad !== 1'b0 || hdr_out !== '0)
            fail_msg("R7", "reset outputs", {31'h0, out_valid}, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 / R8: generate mode, including back-to-back requests
        for (int k = 0; k < 6; k++) send(1'b0, hdrs[k], 8'hFF, "R1");
        for (int b = 0; b < 24; b++) send(1'b0, 24'h1 << b, 8'h00, "R8");
        idle(3);

        // R2: clean check with gaps
        for (int k = 0; k < 6; k++) begin
            send(1'b1, hdrs[k], ref_ecc(hdrs[k]), "R2");
            idle(1);
        end

        // R3 / R6: every single header bit, on two headers
        for (int k = 2; k < 4; k++)
            for (int b = 0; b < 24; b++)
                send(1'b1, hdrs[k] ^ (24'h1 << b), ref_ecc(hdrs[k]), "R3");

        // R6: channel bits flipped, correction and split in one cycle
        send(1'b1, 24'h00003F ^ 24'h40, ref_ecc(24'h00003F), "R6");
        send(1'b1, 24'h00003F ^ 24'h80, ref_ecc(24'h00003F), "R6");
        send(1'b1, 24'h5500C1 ^ 24'h80, ref_ecc(24'h5500C1), "R6");

        // R4: every single ECC bit, including the two fixed-zero bits
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < 8; b++)
                send(1'b1, hdrs[k], ref_ecc(hdrs[k]) ^ (8'h1 << b), "R4");

        // R5: double errors
        for (int b = 0; b < 23; b++)
            send(1'b1, hdrs[4] ^ (24'h3 << b), ref_ecc(hdrs[4]), "R5");
        send(1'b1, hdrs[5] ^ 24'h000001, ref_ecc(hdrs[5]) ^ 8'h80, "R5");
        send(1'b1, hdrs[5], ref_ecc(hdrs[5]) ^ 8'h03, "R5");
        send(1'b1, hdrs[5], ref_ecc(hdrs[5]) ^ 8'hC0, "R5");
        idle(4);

        // R7: all results delivered, no leftovers
        checks++;
        if (q.size() != 0) fail_msg("R7", "pending results", q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule